// File: doc/BRIEF.md
# Three-Leg Dead-Time and Interlock Generator

This block turns six active-low switch commands, one high-side and one low-side command for each of three half-bridge legs, into six active-high gate enables. Every command first passes a glitch filter that discards pulses shorter than a set number of clock cycles. Each leg then goes through a delay line that drops high-side on-requests narrower than a set minimum width. A per-leg interlock follows, which never lets both switches of a leg conduct together. The last stage holds each switch off for a set dead time before either switch of the leg turns on.

The three legs are built from the same generated hardware, so a command edge reaches its gate output after the same number of cycles on all six paths. A build parameter chooses whether the high-side enable is the inverse of its command, which is the default, or follows the command in phase. A synchronous force-off input, driven by a protection block elsewhere on the chip, clears all six enables on the next clock edge and bypasses the filter and dead-time stages. All lengths are elaboration parameters counted in clock cycles.

Top module: `tri_leg_gate_ctl`

## Requirements
- R1: While reset is high, and after reset until a command asks otherwise, all six gate enables are 0.
- R2: A low-side enable is 1 when its command input is 0 and 0 when its command is 1.
- R3: With HI_INPHASE = 0 a high-side enable is 1 when its command is 0. With HI_INPHASE = 1 the enable is 1 when its command is 1.
- R4: The two enables of one leg are never both 1. When both commands of a leg request conduction, both enables of that leg go to 0 and stay there until only one request remains.
- R5: A switch turns on only after both enables of its leg have been 0 for at least DEAD_CYC cycles. When a leg's request moves straight from one switch to the other, the gap is exactly DEAD_CYC cycles.
- R6: A command pulse shorter than FILT_CYC cycles has no effect on any output. A pulse of FILT_CYC cycles or longer passes with its width unchanged.
- R7: A high-side on-request shorter than MIN_HI_CYC cycles never reaches the high-side enable. A request of MIN_HI_CYC cycles or longer produces an enable pulse of the same width.
- R8: From a leg at rest, an enable turns on LAT = FILT_CYC + MIN_HI_CYC + 3 cycles after its command changes. It turns off LAT cycles after the command is released. The latency is the same on all six outputs.
- R9: A cycle with force_off at 1 makes all six enables 0 at the next clock edge. After force_off drops, an enable turns on again only after DEAD_CYC cycles with both enables of its leg at 0.
- R10: Each leg responds only to its own commands. Activity on one leg leaves the enables of the other legs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| force_off | input | 1 | Synchronous request to clear all enables at once |
| hi_cmd_n | input | NUM_LEGS | High-side commands, one bit per leg (active low unless HI_INPHASE = 1) |
| lo_cmd_n | input | NUM_LEGS | Low-side commands, one bit per leg, active low |
| hi_gate | output | NUM_LEGS | High-side gate enables, 1 = switch on |
| lo_gate | output | NUM_LEGS | Low-side gate enables, 1 = switch on |

## Verification
The main path is tested in several ways. Commands are stepped from rest on all legs at once, which exposes any latency mismatch between paths. A direct hand-over from the low switch to the high switch, and back again, measures the dead-time gap in both directions. Both commands of one leg are held active together to exercise the interlock. Pulses one cycle shorter than, and exactly equal to, the filter length and the minimum high width separate dropping from passing at both thresholds. A force-off while two legs conduct shows that the clear happens on the next edge and that the dead time restarts. A second instance built with the in-phase option shows the other high-side polarity.

// File: rtl/tri_leg_pkg.sv
package tri_leg_pkg;

    // One leg's pair of active-high switch requests or enables.
    typedef struct packed {
        logic hi;
        logic lo;
    } pair_t;

    // Conduction state of one leg after the dead-band stage.
    typedef enum logic [1:0] {
        LEG_IDLE = 2'd0,
        LEG_HI   = 2'd1,
        LEG_LO   = 2'd2
    } leg_state_e;

    // Interlock: a leg asking for both switches gets neither.
    function automatic pair_t resolve_pair(pair_t req);
        pair_t w;
        w.hi = req.hi & ~req.lo;
        w.lo = req.lo & ~req.hi;
        return w;
    endfunction

endpackage

// File: rtl/leg_glitch_filter.sv
module leg_glitch_filter #(
    parameter int FILT_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_CYC) + 1;

    logic          raw_q;
    logic          held;
    logic [CW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= 1'b0;
            held  <= 1'b0;
            run   <= '0;
        end else begin
            raw_q <= din;
            if (raw_q == held) begin
                run <= '0;
            end else if (run == CW'(FILT_CYC - 1)) begin
                held <= raw_q;
                run  <= '0;
            end else begin
                run <= run + 1'b1;
            end
        end
    end

    assign dout = held;
endmodule

// File: rtl/leg_pulse_align.sv
module leg_pulse_align
    import tri_leg_pkg::*;
#(
    parameter int MIN_HI_CYC = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  pair_t req,
    output pair_t aligned
);
    localparam int M = MIN_HI_CYC;

    logic [M-1:0] hi_line;
    logic [M-1:0] lo_line;
    logic         hi_q;
    logic         lo_q;

    // Both sides travel through equal-length lines so their latency matches.
    // A high pulse is let out only if the whole line was full when its
    // leading edge reached the end, i.e. it lasted at least M cycles.
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_line <= '0;
            lo_line <= '0;
            hi_q    <= 1'b0;
            lo_q    <= 1'b0;
        end else begin
            hi_line <= (hi_line << 1) | M'(req.hi);
            lo_line <= (lo_line << 1) | M'(req.lo);
            hi_q    <= hi_line[M-1] & (hi_q | (&hi_line));
            lo_q    <= lo_line[M-1];
        end
    end

    assign aligned.hi = hi_q;
    assign aligned.lo = lo_q;
endmodule

// File: rtl/leg_dead_band.sv
module leg_dead_band
    import tri_leg_pkg::*;
#(
    parameter int DEAD_CYC = 5
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  force_off,
    input  pair_t req,
    output pair_t gate
);
    localparam int DW = $clog2(DEAD_CYC + 1) + 1;

    leg_state_e    state, state_nx;
    logic [DW-1:0] off_run, off_run_nx;
    pair_t         want;
    logic          ready;

    always_comb begin
        want  = resolve_pair(req);
        ready = (off_run >= DW'(DEAD_CYC));
        case (state)
            LEG_HI:  state_nx = want.hi ? LEG_HI : LEG_IDLE;
            LEG_LO:  state_nx = want.lo ? LEG_LO : LEG_IDLE;
            default: begin
                if (ready && want.hi)      state_nx = LEG_HI;
                else if (ready && want.lo) state_nx = LEG_LO;
                else                       state_nx = LEG_IDLE;
            end
        endcase
        if (force_off) state_nx = LEG_IDLE;

        if (force_off || state_nx != LEG_IDLE) off_run_nx = '0;
        else if (off_run < DW'(DEAD_CYC))      off_run_nx = off_run + 1'b1;
        else                                   off_run_nx = off_run;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= LEG_IDLE;
            off_run <= '0;
        end else begin
            state   <= state_nx;
            off_run <= off_run_nx;
        end
    end

    assign gate.hi = (state == LEG_HI);
    assign gate.lo = (state == LEG_LO);
endmodule

// File: rtl/tri_leg_gate_ctl.sv
module tri_leg_gate_ctl
    import tri_leg_pkg::*;
#(
    parameter int NUM_LEGS   = 3,
    parameter int FILT_CYC   = 3,
    parameter int MIN_HI_CYC = 8,
    parameter int DEAD_CYC   = 5,
    parameter bit HI_INPHASE = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                force_off,
    input  logic [NUM_LEGS-1:0] hi_cmd_n,
    input  logic [NUM_LEGS-1:0] lo_cmd_n,
    output logic [NUM_LEGS-1:0] hi_gate,
    output logic [NUM_LEGS-1:0] lo_gate
);
    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        pair_t raw_req;
        pair_t filt_req;
        pair_t algn_req;
        pair_t gate_pair;

        if (HI_INPHASE) begin : g_hi_pol
            assign raw_req.hi = hi_cmd_n[g];
        end else begin : g_hi_pol
            assign raw_req.hi = ~hi_cmd_n[g];
        end
        assign raw_req.lo = ~lo_cmd_n[g];

        leg_glitch_filter #(.FILT_CYC(FILT_CYC)) u_filt_hi (
            .clk (clk),
            .rst (rst),
            .din (raw_req.hi),
            .dout(filt_req.hi)
        );

        leg_glitch_filter #(.FILT_CYC(FILT_CYC)) u_filt_lo (
            .clk (clk),
            .rst (rst),
            .din (raw_req.lo),
            .dout(filt_req.lo)
        );

        leg_pulse_align #(.MIN_HI_CYC(MIN_HI_CYC)) u_align (
            .clk    (clk),
            .rst    (rst),
            .req    (filt_req),
            .aligned(algn_req)
        );

        leg_dead_band #(.DEAD_CYC(DEAD_CYC)) u_dead (
            .clk      (clk),
            .rst      (rst),
            .force_off(force_off),
            .req      (algn_req),
            .gate     (gate_pair)
        );

        assign hi_gate[g] = gate_pair.hi;
        assign lo_gate[g] = gate_pair.lo;
    end
endmodule

// File: rtl/tri_leg_gate_ctl_chk.sv
module tri_leg_gate_ctl_chk #(
    parameter int NUM_LEGS = 3,
    parameter int DEAD_CYC = 5
) (
    input logic                clk,
    input logic                rst,
    input logic                force_off,
    input logic [NUM_LEGS-1:0] hi_gate,
    input logic [NUM_LEGS-1:0] lo_gate
);
    localparam int DW = $clog2(DEAD_CYC + 1) + 1;

    assert_force_clear_R9: assert property (@(posedge clk) disable iff (rst)
        force_off |=> (hi_gate == '0 && lo_gate == '0));

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_chk
        logic [DW-1:0] idle_seen;

        always_ff @(posedge clk) begin
            if (rst)                               idle_seen <= '0;
            else if (hi_gate[g] || lo_gate[g])     idle_seen <= '0;
            else if (idle_seen < DW'(DEAD_CYC))    idle_seen <= idle_seen + 1'b1;
        end

        assert_leg_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
            $onehot0({hi_gate[g], lo_gate[g]}));

        assert_dead_hi_R5: assert property (@(posedge clk) disable iff (rst)
            $rose(hi_gate[g]) |-> (idle_seen >= DW'(DEAD_CYC)));

        assert_dead_lo_R5: assert property (@(posedge clk) disable iff (rst)
            $rose(lo_gate[g]) |-> (idle_seen >= DW'(DEAD_CYC)));
    end
endmodule

bind tri_leg_gate_ctl tri_leg_gate_ctl_chk #(
    .NUM_LEGS(NUM_LEGS),
    .DEAD_CYC(DEAD_CYC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .force_off(force_off),
    .hi_gate  (hi_gate),
    .lo_gate  (lo_gate)
);

// File: tb/tri_leg_gate_ctl_test.sv
module tri_leg_gate_ctl_test;
    localparam int LEGS = 3;
    localparam int FILT = 3;
    localparam int MINH = 8;
    localparam int DEAD = 5;
    localparam int LAT  = FILT + MINH + 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            force_off = 1'b0;
    logic [LEGS-1:0] hi_cmd_n = '1;
    logic [LEGS-1:0] lo_cmd_n = '1;
    logic [LEGS-1:0] hi_gate, lo_gate;
    logic [LEGS-1:0] ip_hi = '0;
    logic [LEGS-1:0] ip_hi_gate, ip_lo_gate;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    tri_leg_gate_ctl #(.NUM_LEGS(LEGS), .FILT_CYC(FILT), .MIN_HI_CYC(MINH),
                       .DEAD_CYC(DEAD), .HI_INPHASE(1'b0)) uut (
        .clk(clk), .rst(rst), .force_off(force_off),
        .hi_cmd_n(hi_cmd_n), .lo_cmd_n(lo_cmd_n),
        .hi_gate(hi_gate), .lo_gate(lo_gate));

    tri_leg_gate_ctl #(.NUM_LEGS(LEGS), .FILT_CYC(FILT), .MIN_HI_CYC(MINH),
                       .DEAD_CYC(DEAD), .HI_INPHASE(1'b1)) uut_inph (
        .clk(clk), .rst(rst), .force_off(force_off),
        .hi_cmd_n(ip_hi), .lo_cmd_n('1),
        .hi_gate(ip_hi_gate), .lo_gate(ip_lo_gate));

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic expect_val(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic settle();
        hi_cmd_n = '1;
        lo_cmd_n = '1;
        ip_hi    = '0;
        ticks(LAT + 3 * DEAD + 10);
    endtask

    task automatic t_reset();
        ticks(3);
        expect_val("R1 gates during reset", {hi_gate, lo_gate}, 0);
        rst = 1'b0;
        ticks(LAT + 10);
        expect_val("R1 gates after reset", {hi_gate, lo_gate}, 0);
        expect_val("R1 inphase gates after reset", {ip_hi_gate, ip_lo_gate}, 0);
    endtask

    task automatic t_low_latency();
        lo_cmd_n = '0;
        ticks(LAT - 1);
        expect_val("R8 lo before latency", lo_gate, 0);
        tick();
        expect_val("R2 R8 lo on all legs", lo_gate, 7);
        expect_val("R4 hi stays off", hi_gate, 0);
        lo_cmd_n = '1;
        ticks(LAT - 1);
        expect_val("R8 lo held before off latency", lo_gate, 7);
        tick();
        expect_val("R2 R8 lo off all legs", lo_gate, 0);
        settle();
    endtask

    task automatic t_high_latency();
        hi_cmd_n = '0;
        ticks(LAT - 1);
        expect_val("R8 hi before latency", hi_gate, 0);
        tick();
        expect_val("R3 R8 hi on all legs", hi_gate, 7);
        hi_cmd_n = '1;
        ticks(LAT - 1);
        expect_val("R8 hi held before off latency", hi_gate, 7);
        tick();
        expect_val("R3 R8 hi off all legs", hi_gate, 0);
        settle();
    endtask

    task automatic t_inphase();
        ip_hi = 3'b101;
        ticks(LAT - 1);
        expect_val("R3 inphase before latency", ip_hi_gate, 0);
        tick();
        expect_val("R3 inphase hi follows command", ip_hi_gate, 5);
        ip_hi = '0;
        ticks(LAT);
        expect_val("R3 inphase hi off", ip_hi_gate, 0);
        settle();
    endtask

    task automatic t_dead_time();
        lo_cmd_n[0] = 1'b0;
        ticks(LAT + 5);
        expect_val("R2 leg0 lo on", lo_gate[0], 1);
        hi_cmd_n[0] = 1'b0;
        lo_cmd_n[0] = 1'b1;
        ticks(LAT - 1);
        expect_val("R5 lo still on", lo_gate[0], 1);
        tick();
        expect_val("R5 lo off at handover", {hi_gate[0], lo_gate[0]}, 0);
        ticks(DEAD - 1);
        expect_val("R5 hi off inside dead time", hi_gate[0], 0);
        tick();
        expect_val("R5 hi on after dead time", hi_gate[0], 1);
        expect_val("R10 other legs idle", {hi_gate[2:1], lo_gate[2:1]}, 0);
        hi_cmd_n[0] = 1'b1;
        lo_cmd_n[0] = 1'b0;
        ticks(LAT);
        expect_val("R5 hi off at handover back", {hi_gate[0], lo_gate[0]}, 0);
        ticks(DEAD - 1);
        expect_val("R5 lo off inside dead time", lo_gate[0], 0);
        tick();
        expect_val("R5 lo on after dead time", lo_gate[0], 1);
        settle();
    endtask

    task automatic t_conflict();
        int bad;
        bad = 0;
        hi_cmd_n[1] = 1'b0;
        lo_cmd_n[1] = 1'b0;
        for (int i = 0; i < LAT + 10; i++) begin
            tick();
            if (hi_gate[1] || lo_gate[1]) bad++;
        end
        expect_val("R4 both requested gives both off", bad, 0);
        lo_cmd_n[1] = 1'b1;
        ticks(LAT - 1);
        expect_val("R4 hi waits for lo release", hi_gate[1], 0);
        tick();
        expect_val("R4 hi on once alone", hi_gate[1], 1);
        lo_cmd_n[1] = 1'b0;
        ticks(LAT - 1);
        expect_val("R4 hi held before conflict arrives", hi_gate[1], 1);
        tick();
        expect_val("R4 conflict clears leg", {hi_gate[1], lo_gate[1]}, 0);
        ticks(20);
        expect_val("R4 leg stays off in conflict", {hi_gate[1], lo_gate[1]}, 0);
        expect_val("R10 legs 0 and 2 untouched", {hi_gate[2], hi_gate[0], lo_gate[2], lo_gate[0]}, 0);
        settle();
    endtask

    task automatic pulse_lo2(int width, output int seen);
        seen = 0;
        lo_cmd_n[2] = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (i == width) lo_cmd_n[2] = 1'b1;
            tick();
            if (lo_gate[2]) seen++;
        end
        lo_cmd_n[2] = 1'b1;
    endtask

    task automatic pulse_hi0(int width, output int seen);
        seen = 0;
        hi_cmd_n[0] = 1'b0;
        for (int i = 0; i < 50; i++) begin
            if (i == width) hi_cmd_n[0] = 1'b1;
            tick();
            if (hi_gate[0]) seen++;
        end
        hi_cmd_n[0] = 1'b1;
    endtask

    task automatic t_glitch();
        int seen;
        pulse_lo2(FILT - 1, seen);
        expect_val("R6 short pulse ignored", seen, 0);
        settle();
        pulse_lo2(FILT, seen);
        expect_val("R6 pulse at filter length passes", seen, FILT);
        settle();
        pulse_hi0(1, seen);
        expect_val("R6 one-cycle hi glitch ignored", seen, 0);
        settle();
    endtask

    task automatic t_min_width();
        int seen;
        pulse_hi0(MINH - 1, seen);
        expect_val("R7 narrow hi request dropped", seen, 0);
        settle();
        pulse_hi0(MINH, seen);
        expect_val("R7 hi request at minimum passes", seen, MINH);
        settle();
        pulse_hi0(MINH + 4, seen);
        expect_val("R7 wider hi request keeps width", seen, MINH + 4);
        settle();
    endtask

    task automatic t_force();
        lo_cmd_n[0] = 1'b0;
        hi_cmd_n[1] = 1'b0;
        ticks(LAT + 10);
        expect_val("R9 setup gates on", {hi_gate, lo_gate}, 6'b010_001);
        force_off = 1'b1;
        tick();
        force_off = 1'b0;
        expect_val("R9 force clears next edge", {hi_gate, lo_gate}, 0);
        ticks(DEAD);
        expect_val("R9 dead time after force", {hi_gate, lo_gate}, 0);
        tick();
        expect_val("R9 R10 gates return after dead time", {hi_gate, lo_gate}, 6'b010_001);
        settle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_low_latency();
        t_high_latency();
        t_inphase();
        t_dead_time();
        t_conflict();
        t_glitch();
        t_min_width();
        t_force();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule